// File: doc/BRIEF.md
# ULPI Link UART-Mode Sequencer

This block sits on the link side of a ULPI bus. It moves the transceiver into transparent UART mode and brings it back out. On a start request it sends four register writes. These set the speed of the transceiver selector, clear the termination, set both data-line pull-downs in one write, and enable the carkit data paths. The last write sets the carkit-mode bit together with an optional clock-keep bit. It then waits for the transceiver to take the bus. After that single turnaround cycle it drives DATA0 as the UART transmit line and passes DATA1 through as UART receive.

In UART mode the interrupt line is latched. An exit request or a latched interrupt makes the sequencer hold STP high until the transceiver releases DIR. After an interrupt wake it also issues a read command for the interrupt-latch register. A separate chip-select reset drops chip select for a counted power-down time, raises it again and waits for the bus to return to synchronous mode. A status output reports the current phase.

Top module: `ulpi_uart_seq`

## Requirements
- R1: While rst_ni is low and after its release, state_o is 0 (SYNC), cs_o is 1, ulpi_stp_o is 0 and ulpi_data_oe_o is 0.
- R2: A register write sends the command byte {2'b10, addr[5:0]} with all eight data lines enabled, holding it until NXT is sampled high. It then drives the data byte until NXT is sampled high, then raises STP for exactly one cycle.
- R3: After start_i in SYNC, four writes go out in this order:
  - address 0x04 with data 0x42, or 0x41 when fs_mode_i=1 (selector field bits 1:0 = 10b low speed / 01b full speed, termination bit 2 = 0, suspend bit 6 = 1);
  - address 0x0A with data 0x06 (both pull-down bits 1 and 2 in one write);
  - address 0x19 with data 0x0C (transmit enable bit 2, receive enable bit 3);
  - last, address 0x07 with data 0x04, with bit 3 (clock keep) also set when keep_clk_i=1.
- R4: If DIR is high while a write is in its command or data phase, the link releases the data bus at once. It restarts that write from its command byte once DIR is low, so each register is still written exactly once.
- R5: After the last write, state_o is 2 (ENTER_UART). At the first clock edge with DIR high it becomes 3 (UART). From then on the link drives only DATA0 (ulpi_data_oe_o = 8'h01), with DATA0 equal to uart_txd_i, and uart_rxd_o follows DATA1.
- R6: int_i high in UART sets int_pend_o on the next edge. The read command for the interrupt-latch register clears it when it is accepted.
- R7: exit_i, or a pending interrupt, in UART moves to state 4 (EXITING) with STP held high and the bus released until DIR is low. If an interrupt is pending, a read command {2'b11, 6'h14} is then held until NXT. The block then returns to SYNC.
- R8: cs_reset_i in UART takes priority over exit_i and interrupts. cs_o goes low for exactly CS_HOLD_CYC cycles without STP, then high. State stays EXITING until DIR is low, then goes to SYNC with int_pend_o cleared.
- R9: state_o encodes 0 SYNC, 1 CONFIG, 2 ENTER_UART, 3 UART, 4 EXITING, and UART is left only for EXITING.
- R10: start_i has no effect outside SYNC. exit_i and cs_reset_i have no effect outside UART.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | ULPI clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request UART entry |
| fs_mode_i | input | 1 | 1 selects full-speed UART edges, 0 low-speed |
| keep_clk_i | input | 1 | Keep CLOCK running in UART mode |
| exit_i | input | 1 | Request exit through STP |
| cs_reset_i | input | 1 | Request exit through chip-select power cycle |
| uart_txd_i | input | 1 | UART transmit data, sent on DATA0 |
| int_i | input | 1 | Transceiver interrupt line |
| ulpi_dir_i | input | 1 | ULPI DIR |
| ulpi_nxt_i | input | 1 | ULPI NXT |
| ulpi_data_i | input | 8 | ULPI data bus, inbound |
| ulpi_data_o | output | 8 | ULPI data bus, outbound |
| ulpi_data_oe_o | output | 8 | Per-line output enable for the data bus |
| ulpi_stp_o | output | 1 | ULPI STP |
| cs_o | output | 1 | Chip select, active high |
| uart_rxd_o | output | 1 | UART receive data taken from DATA1 |
| int_pend_o | output | 1 | Latched interrupt awaiting service |
| state_o | output | 3 | Sequencer phase |

## Verification
The bench raises DIR in the middle of the first command to force an abort. A design that resumes at the data byte, or that drives the bus during DIR, would log a wrong or extra write. The bench counts the chip-select low cycles one by one, so a counter that is off by one shows up as a wrong length. It also raises an interrupt together with a chip-select reset: a design with the wrong priority would pulse STP or leave the interrupt pending. The bench checks both speed settings and the clock-keep bit in the logged write bytes, and checks that STP never stays high past one cycle.

// File: rtl/ulpi_uart_pkg.sv
package ulpi_uart_pkg;
  typedef enum logic [2:0] {
    ST_SYNC   = 3'd0,
    ST_CONFIG = 3'd1,
    ST_ENTER  = 3'd2,
    ST_UART   = 3'd3,
    ST_EXIT   = 3'd4
  } seq_state_e;

  typedef enum logic [1:0] {X_STP, X_READ, X_CSLOW, X_CSWAIT} exit_ph_e;

  typedef enum logic [2:0] {W_IDLE, W_CMD, W_DATA, W_STP, W_HOLD} wr_state_e;

  typedef struct packed {
    logic [5:0] addr;
    logic [7:0] data;
  } reg_wr_t;

  localparam int N_CFG = 4;

  localparam logic [5:0] A_FUNC   = 6'h04;
  localparam logic [5:0] A_IFC    = 6'h07;
  localparam logic [5:0] A_OTG    = 6'h0A;
  localparam logic [5:0] A_CARKIT = 6'h19;
  localparam logic [5:0] A_INTLAT = 6'h14;

  localparam logic [7:0] FUNC_SUSP = 8'h40;
  localparam logic [7:0] SEL_LS    = 8'h02;
  localparam logic [7:0] SEL_FS    = 8'h01;
  localparam logic [7:0] OTG_PD    = 8'h06;
  localparam logic [7:0] CK_TXRX   = 8'h0C;
  localparam logic [7:0] IFC_CKM   = 8'h04;
  localparam logic [7:0] IFC_CLK   = 8'h08;
endpackage

// File: rtl/ulpi_reg_port.sv
module ulpi_reg_port
  import ulpi_uart_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_i,
  input  logic       rd_i,
  input  reg_wr_t    op_i,
  input  logic       dir_i,
  input  logic       nxt_i,
  output logic [7:0] data_o,
  output logic       oe_o,
  output logic       stp_o,
  output logic       done_o
);
  wr_state_e st;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st <= W_IDLE;
    else begin
      unique case (st)
        W_IDLE: if (req_i) st <= W_CMD;
        W_CMD: begin
          if (dir_i)      st <= W_HOLD;
          else if (nxt_i) st <= rd_i ? W_IDLE : W_DATA;
        end
        W_DATA: begin
          if (dir_i)      st <= W_HOLD;
          else if (nxt_i) st <= W_STP;
        end
        W_STP:  st <= W_IDLE;
        W_HOLD: if (!dir_i) st <= W_CMD;
        default: st <= W_IDLE;
      endcase
    end
  end

  always_comb begin
    data_o = 8'h00;
    if (st == W_CMD)  data_o = {rd_i ? 2'b11 : 2'b10, op_i.addr};
    if (st == W_DATA) data_o = op_i.data;
  end

  assign oe_o   = (st == W_CMD || st == W_DATA || st == W_STP) && !dir_i;
  assign stp_o  = (st == W_STP);
  assign done_o = (st == W_STP) || (st == W_CMD && rd_i && nxt_i && !dir_i);

  // R2
  stp_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stp_o |=> !stp_o);
  // R2
  data_after_nxt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == W_DATA && $past(st) == W_CMD) |-> $past(nxt_i));
  // R4
  abort_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((st == W_CMD || st == W_DATA) && dir_i) |=> st == W_HOLD);
endmodule

// File: rtl/ulpi_cs_timer.sv
module ulpi_cs_timer #(
  parameter int HOLD = 600
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic hold_o,
  output logic done_o
);
  localparam int CNT_W = $clog2(HOLD + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HOLD - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_o <= 1'b0;
      cnt    <= '0;
    end else if (start_i) begin
      hold_o <= 1'b1;
      cnt    <= '0;
    end else if (hold_o) begin
      if (cnt == LAST) hold_o <= 1'b0;
      else cnt <= cnt + 1'b1;
    end
  end

  assign done_o = hold_o && (cnt == LAST);

  // R8
  hold_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(hold_o) && !$past(start_i)) |-> $past(cnt) == LAST);
  // R8
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt <= LAST);
endmodule

// File: rtl/ulpi_int_latch.sv
module ulpi_int_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic pend_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    pend_o <= 1'b0;
    else if (clr_i) pend_o <= 1'b0;
    else if (set_i) pend_o <= 1'b1;
  end

  // R6
  pend_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pend_o) |-> $past(set_i));
endmodule

// File: rtl/ulpi_uart_seq.sv
module ulpi_uart_seq
  import ulpi_uart_pkg::*;
#(
  parameter int CS_HOLD_CYC = 600
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       fs_mode_i,
  input  logic       keep_clk_i,
  input  logic       exit_i,
  input  logic       cs_reset_i,
  input  logic       uart_txd_i,
  input  logic       int_i,
  input  logic       ulpi_dir_i,
  input  logic       ulpi_nxt_i,
  input  logic [7:0] ulpi_data_i,
  output logic [7:0] ulpi_data_o,
  output logic [7:0] ulpi_data_oe_o,
  output logic       ulpi_stp_o,
  output logic       cs_o,
  output logic       uart_rxd_o,
  output logic       int_pend_o,
  output logic [2:0] state_o
);
  localparam int STEP_W = $clog2(N_CFG);
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(N_CFG - 1);

  seq_state_e        state;
  exit_ph_e          xph;
  logic [STEP_W-1:0] step;
  reg_wr_t           cur;
  logic              w_req, w_rd, w_oe, w_stp, w_done;
  logic [7:0]        w_data;
  logic              t_start, t_hold, t_done;
  logic              i_set, i_clr;
  logic              unused_bits;

  function automatic reg_wr_t cfg_entry(input logic [STEP_W-1:0] idx,
                                        input logic fs, input logic keep);
    reg_wr_t e;
    unique case (idx)
      2'd0:    begin e.addr = A_FUNC;   e.data = FUNC_SUSP | (fs ? SEL_FS : SEL_LS); end
      2'd1:    begin e.addr = A_OTG;    e.data = OTG_PD; end
      2'd2:    begin e.addr = A_CARKIT; e.data = CK_TXRX; end
      default: begin e.addr = A_IFC;    e.data = IFC_CKM | (keep ? IFC_CLK : 8'h00); end
    endcase
    return e;
  endfunction

  always_comb begin
    if (state == ST_EXIT) begin
      cur.addr = A_INTLAT;
      cur.data = 8'h00;
    end else begin
      cur = cfg_entry(step, fs_mode_i, keep_clk_i);
    end
  end

  assign w_req   = (state == ST_CONFIG) || (state == ST_EXIT && xph == X_READ);
  assign w_rd    = (state == ST_EXIT);
  assign t_start = (state == ST_UART) && cs_reset_i;
  assign i_set   = (state == ST_UART) && int_i;
  assign i_clr   = (state == ST_EXIT) &&
                   ((xph == X_READ && w_done) || xph == X_CSLOW);

  ulpi_reg_port u_port (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (w_req),
    .rd_i   (w_rd),
    .op_i   (cur),
    .dir_i  (ulpi_dir_i),
    .nxt_i  (ulpi_nxt_i),
    .data_o (w_data),
    .oe_o   (w_oe),
    .stp_o  (w_stp),
    .done_o (w_done)
  );

  ulpi_cs_timer #(.HOLD(CS_HOLD_CYC)) u_tmr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (t_start),
    .hold_o  (t_hold),
    .done_o  (t_done)
  );

  ulpi_int_latch u_int (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (i_set),
    .clr_i  (i_clr),
    .pend_o (int_pend_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state <= ST_SYNC;
      xph   <= X_STP;
      step  <= '0;
    end else begin
      unique case (state)
        ST_SYNC: if (start_i) begin
          state <= ST_CONFIG;
          step  <= '0;
        end
        ST_CONFIG: if (w_done) begin
          if (step == LAST_STEP) state <= ST_ENTER;
          else step <= step + 1'b1;
        end
        ST_ENTER: if (ulpi_dir_i) state <= ST_UART;
        ST_UART: begin
          if (cs_reset_i) begin
            state <= ST_EXIT;
            xph   <= X_CSLOW;
          end else if (exit_i || int_pend_o) begin
            state <= ST_EXIT;
            xph   <= X_STP;
          end
        end
        ST_EXIT: begin
          unique case (xph)
            X_STP:    if (!ulpi_dir_i) begin
              if (int_pend_o) xph <= X_READ;
              else state <= ST_SYNC;
            end
            X_READ:   if (w_done) state <= ST_SYNC;
            X_CSLOW:  if (t_done) xph <= X_CSWAIT;
            X_CSWAIT: if (!ulpi_dir_i) state <= ST_SYNC;
            default:  state <= ST_SYNC;
          endcase
        end
        default: state <= ST_SYNC;
      endcase
    end
  end

  always_comb begin
    ulpi_data_o    = 8'h00;
    ulpi_data_oe_o = 8'h00;
    if (w_req) begin
      ulpi_data_o    = w_data;
      ulpi_data_oe_o = {8{w_oe}};
    end else if (state == ST_UART) begin
      ulpi_data_o    = {7'b0, uart_txd_i};
      ulpi_data_oe_o = 8'h01;
    end
  end

  assign ulpi_stp_o  = w_stp || (state == ST_EXIT && xph == X_STP);
  assign cs_o        = !t_hold;
  assign uart_rxd_o  = ulpi_data_i[1];
  assign state_o     = state;
  assign unused_bits = ^{ulpi_data_i[7:2], ulpi_data_i[0]};

  // R9
  uart_leave_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state == ST_UART |=> (state == ST_UART || state == ST_EXIT));
  // R5
  enter_uart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_ENTER && ulpi_dir_i) |=> state == ST_UART);
  // R8
  cs_low_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_o |-> state == ST_EXIT);
  // R8
  cs_no_stp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_o |-> !ulpi_stp_o);
  // R4
  no_drive_dir_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state != ST_UART && ulpi_dir_i) |-> ulpi_data_oe_o == 8'h00);
endmodule

// File: tb/sim_ulpi_uart_seq.sv
module sim_ulpi_uart_seq;
  localparam int HOLD = 12;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0;
  logic start = 0, fs = 0, keep = 0, ex = 0, csr = 0, txd = 1, irq = 0;
  logic dir_t = 0, dir_a = 0, nxt = 0;
  logic dir;
  logic [7:0] din = 8'h00;
  logic [7:0] dout, oe;
  logic stp, cs, rxd, pend;
  logic [2:0] st;

  assign dir = dir_t | dir_a;

  ulpi_uart_seq #(.CS_HOLD_CYC(HOLD)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .fs_mode_i(fs),
    .keep_clk_i(keep), .exit_i(ex), .cs_reset_i(csr), .uart_txd_i(txd),
    .int_i(irq), .ulpi_dir_i(dir), .ulpi_nxt_i(nxt), .ulpi_data_i(din),
    .ulpi_data_o(dout), .ulpi_data_oe_o(oe), .ulpi_stp_o(stp), .cs_o(cs),
    .uart_rxd_o(rxd), .int_pend_o(pend), .state_o(st)
  );

  int errs = 0, checks = 0;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural transceiver: logs register writes and reads
  int ph = 0, wcnt = 0, rcnt = 0, stp_bad = 0, ab_hit = 0, ab_bad = 0;
  bit ab_arm = 0;
  logic [5:0] cur_a, last_ra;
  logic [7:0] cur_d;
  logic [5:0] wa [0:31];
  logic [7:0] wd [0:31];

  always @(negedge clk) begin
    case (ph)
      0: begin
        if (oe == 8'hFF && dout[7:6] == 2'b10) begin
          if (ab_arm) begin ab_arm = 0; dir_a = 1; ph = 4; end
          else begin cur_a = dout[5:0]; nxt = 1; ph = 1; end
        end else if (oe == 8'hFF && dout[7:6] == 2'b11) begin
          last_ra = dout[5:0]; nxt = 1; ph = 3;
        end
      end
      1: begin cur_d = dout; ph = 2; end
      2: begin
        nxt = 0;
        if (!stp) stp_bad++;
        wa[wcnt] = cur_a; wd[wcnt] = cur_d; wcnt++;
        ph = 5;
      end
      3: begin nxt = 0; rcnt++; ph = 0; end
      4: begin if (oe != 8'h00) ab_bad++; ab_hit++; dir_a = 0; ph = 0; end
      5: begin if (stp) stp_bad++; ph = 0; end
      default: ph = 0;
    endcase
  end

  task automatic t_reset();
    rst_n = 0;
    repeat (3) @(negedge clk);
    chk("R1 state in reset", st, 0);
    chk("R1 cs in reset", cs, 1);
    rst_n = 1;
    @(negedge clk);
    chk("R1 state", st, 0);
    chk("R1 stp", stp, 0);
    chk("R1 oe", oe, 0);
  endtask

  task automatic t_enter(input bit f, input bit k, input bit abort);
    int base = wcnt;
    int ab0 = ab_hit;
    fs = f; keep = k; ab_arm = abort;
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
    chk("R9 config code", st, 1);
    wait (wcnt == base + 4);
    @(negedge clk);
    chk("R5 enter code", st, 2);
    chk("R3 write count", wcnt - base, 4);
    chk("R3 func addr", wa[base], 8'h04);
    chk("R3 func data", wd[base], f ? 8'h41 : 8'h42);
    chk("R3 otg addr", wa[base+1], 8'h0A);
    chk("R3 otg pulldowns", wd[base+1], 8'h06);
    chk("R3 carkit addr", wa[base+2], 8'h19);
    chk("R3 carkit data", wd[base+2], 8'h0C);
    chk("R3 ifc addr", wa[base+3], 8'h07);
    chk("R3 ifc data", wd[base+3], k ? 8'h0C : 8'h04);
    chk("R2 stp one cycle", stp_bad, 0);
    if (abort) begin
      chk("R4 abort seen", ab_hit - ab0, 1);
      chk("R4 bus released", ab_bad, 0);
    end
    dir_t = 1;
    @(negedge clk);
    chk("R5 uart code", st, 3);
    chk("R5 oe", oe, 8'h01);
    txd = 1; din = 8'h02; #1;
    chk("R5 txd high", dout[0], 1);
    chk("R5 rxd high", rxd, 1);
    txd = 0; din = 8'h00; #1;
    chk("R5 txd low", dout[0], 0);
    chk("R5 rxd low", rxd, 0);
    txd = 1;
  endtask

  task automatic t_ignore_sync();
    @(negedge clk) begin ex = 1; csr = 1; end
    @(negedge clk) begin ex = 0; csr = 0; end
    chk("R10 sync state", st, 0);
    chk("R10 sync cs", cs, 1);
    chk("R10 sync stp", stp, 0);
  endtask

  task automatic t_ignore_uart();
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
    chk("R10 start in uart", st, 3);
  endtask

  task automatic t_stp_exit();
    int r0 = rcnt;
    @(negedge clk) ex = 1;
    @(negedge clk) ex = 0;
    chk("R7 exiting code", st, 4);
    chk("R7 stp held", stp, 1);
    chk("R7 bus released", oe, 0);
    dir_t = 0;
    @(negedge clk);
    chk("R7 back to sync", st, 0);
    chk("R7 stp low", stp, 0);
    chk("R7 no read", rcnt - r0, 0);
  endtask

  task automatic t_int_exit();
    int r0 = rcnt;
    @(negedge clk) irq = 1;
    @(negedge clk) irq = 0;
    chk("R6 pend set", pend, 1);
    chk("R6 still uart", st, 3);
    @(negedge clk);
    chk("R7 int exit code", st, 4);
    chk("R7 int stp", stp, 1);
    dir_t = 0;
    wait (rcnt == r0 + 1);
    chk("R7 read addr", last_ra, 8'h14);
    chk("R7 sync after read", st, 0);
    chk("R6 pend cleared", pend, 0);
  endtask

  task automatic t_cs_exit();
    int n = 0;
    @(negedge clk) begin csr = 1; irq = 1; ex = 1; end
    @(negedge clk) begin csr = 0; irq = 0; ex = 0; end
    chk("R8 no stp", stp, 0);
    for (int i = 0; i < 4 * HOLD && cs == 0; i++) begin
      n++;
      @(negedge clk);
    end
    chk("R8 cs low cycles", n, HOLD);
    chk("R8 wait dir", st, 4);
    dir_t = 0;
    @(negedge clk);
    chk("R8 sync", st, 0);
    chk("R8 pend cleared", pend, 0);
  endtask

  initial begin
    t_reset();
    t_ignore_sync();
    t_enter(0, 0, 0);
    t_ignore_uart();
    t_stp_exit();
    t_enter(1, 1, 1);
    t_int_exit();
    t_enter(0, 1, 0);
    t_cs_exit();
    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule